// File: doc/BRIEF.md
# Self-Triggered Front-End Acquisition and Trigger-Timing Controller

This block is the control logic on a detector card that carries several self-triggering readout chips. It runs from a single fine clock. It keeps a coarse bunch-crossing timestamp that advances once every `BC_DIV` fine cycles and is local to the card. It also keeps a fine counter that measures how long ago any chip last fired. Offline software rebuilds the time of a hit from two values: the hit's timestamp minus the timestamp latched on the external trigger, and the fine count latched on that same trigger. Both values are therefore captured together.

The controller also sequences acquisition. While acquiring, an external trigger freezes the chips. The latched values are held while the chips are read out, and acquisition resumes once the readout-done handshake arrives. If any chip reports that its event memory is full, the controller sends a one-cycle clear to every chip. It then waits a fixed settle interval before re-enabling acquisition, and the timestamp restarts from zero. Three counters track the triggers: one for all external triggers, one for those accepted during acquisition, and one for those that arrive while the card is busy. A sticky flag records that a memory-full recovery took place and is cleared by a status read.

Top module: `acq_timing_ctrl`

## Requirements
- R1: After reset the timestamp `bc_now` is 0 and increments by one every `BC_DIV` clock cycles, wrapping modulo 2^`BC_W`.
- R2: `bc_now` and its prescaler return to 0 on the edge that samples `card_reset` high or that accepts a memory-full; `card_reset` leaves the counters, latches and flag unchanged.
- R3: A chip hit is its threshold-0 line OR its threshold-1 line. A hit from any chip while `acq_en` is high zeroes `fine_now`. Otherwise `fine_now` increments each cycle and saturates at 2^`FINE_W`-1. Hits while `acq_en` is low have no effect.
- R4: An external trigger while `acq_en` is high latches `bc_now` into `lat_bc` and `fine_now` into `lat_fine` (0 if a hit coincides). From the next cycle `acq_en` is low and `busy` is high until the edge that samples `ro_done` high.
- R5: Every external trigger increments `evt_count`. Triggers accepted during acquisition increment `ext_in_acq`, and those seen while `acq_en` is low increment `ext_out_acq`. All three counters wrap modulo 2^`CNT_W`.
- R6: A memory-full line seen while acquiring, with no external trigger in the same cycle, starts a recovery. The next cycle has `mem_clear` high for exactly one cycle. `SETTLE_CYC` busy cycles follow, and then `acq_en` returns high. Memory-full lines are ignored when `acq_en` is low.
- R7: An external trigger takes priority over a memory-full in the same cycle: the block enters readout and no clear is issued.
- R8: `full_seen` is set on the edge that accepts a memory-full and cleared by `stat_rd`; if both happen on the same edge, setting wins.
- R9: `busy` is always the inverse of `acq_en`, and `mem_clear` is high only while `busy` is high.
- R10: After reset, `acq_en` is high and all counters, latches, `fine_now` and `full_seen` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fine clock (one fine count per cycle) |
| rst | input | 1 | Synchronous active-high reset |
| card_reset | input | 1 | Restarts the timestamp only |
| thr0 | input | N_CHIPS | Threshold-0 trigger line of each chip |
| thr1 | input | N_CHIPS | Threshold-1 trigger line of each chip |
| chip_full | input | N_CHIPS | Event memory full, one per chip |
| ext_trig | input | 1 | External trigger, one cycle per trigger |
| ro_done | input | 1 | Readout finished handshake |
| stat_rd | input | 1 | Status read strobe, clears `full_seen` |
| busy | output | 1 | Card not acquiring |
| acq_en | output | 1 | Acquisition enable to the chips |
| mem_clear | output | 1 | Memory clear pulse to all chips |
| bc_now | output | BC_W | Live bunch-crossing timestamp |
| fine_now | output | FINE_W | Live fine counter |
| lat_bc | output | BC_W | Timestamp latched on accepted trigger |
| lat_fine | output | FINE_W | Fine count latched on accepted trigger |
| evt_count | output | CNT_W | All external triggers |
| ext_in_acq | output | CNT_W | External triggers accepted during acquisition |
| ext_out_acq | output | CNT_W | External triggers seen while busy |
| full_seen | output | 1 | Memory-full recovery since last status read |

## Verification
The bench builds the block with four chips, `BC_DIV`=8, an 8-bit timestamp, a 5-bit fine counter, 4-bit trigger counters and a 4-cycle settle interval. The 5-bit fine counter reaches saturation after 31 idle cycles. The 4-bit counters wrap after sixteen triggers, and the timestamp wraps within a few thousand cycles. Every chip and every threshold combination is swept for hits and memory-full. All outputs are compared on every cycle against arithmetic expectations: cycles since the last timestamp reset divided by eight, and cycles since the last hit clamped at 31.

// File: rtl/acqt_pkg.sv
package acqt_pkg;

    // Control phase of the card.
    typedef enum logic [1:0] {
        PH_ACQ    = 2'd0,
        PH_CLEAR  = 2'd1,
        PH_SETTLE = 2'd2,
        PH_READ   = 2'd3
    } acq_phase_t;

    // Per-cycle decisions taken by the sequencer.
    typedef struct packed {
        logic take_trig;   // external trigger accepted during acquisition
        logic take_full;   // memory-full accepted, recovery starts
        logic stray_trig;  // external trigger seen while busy
    } acq_evt_t;

    function automatic logic phase_is_busy(acq_phase_t p);
        return p != PH_ACQ;
    endfunction

endpackage

// File: rtl/acqt_bc_stamp.sv
module acqt_bc_stamp #(
    parameter int BC_W   = 24,
    parameter int BC_DIV = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            zero,
    output logic [BC_W-1:0] bc
);
    localparam int PW = (BC_DIV > 2) ? $clog2(BC_DIV) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(BC_DIV - 1);

    logic [PW-1:0] pre;

    always_ff @(posedge clk) begin
        if (rst || zero) begin
            pre <= '0;
            bc  <= '0;
        end else if (pre == PRE_LAST) begin
            pre <= '0;
            bc  <= bc + BC_W'(1);
        end else begin
            pre <= pre + PW'(1);
        end
    end
endmodule

// File: rtl/acqt_fine_timer.sv
module acqt_fine_timer #(
    parameter int FINE_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    output logic [FINE_W-1:0] fine
);
    always_ff @(posedge clk) begin
        if (rst || restart) begin
            fine <= '0;
        end else if (fine != '1) begin
            fine <= fine + FINE_W'(1);
        end
    end
endmodule

// File: rtl/acqt_sequencer.sv
module acqt_sequencer
    import acqt_pkg::*;
#(
    parameter int N_CHIPS    = 4,
    parameter int SETTLE_CYC = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_CHIPS-1:0] chip_full,
    input  logic               ext_trig,
    input  logic               ro_done,
    output acq_phase_t         phase,
    output acq_evt_t           evt
);
    localparam int SW = $clog2(SETTLE_CYC + 1);
    localparam logic [SW-1:0] SETTLE_LOAD = SW'(SETTLE_CYC - 1);

    logic [SW-1:0] settle_left;
    logic          acquiring;

    assign acquiring      = (phase == PH_ACQ);
    assign evt.take_trig  = acquiring && ext_trig;
    assign evt.take_full  = acquiring && !ext_trig && (|chip_full);
    assign evt.stray_trig = !acquiring && ext_trig;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase       <= PH_ACQ;
            settle_left <= '0;
        end else begin
            unique case (phase)
                PH_ACQ: begin
                    if (evt.take_trig) begin
                        phase <= PH_READ;
                    end else if (evt.take_full) begin
                        phase <= PH_CLEAR;
                    end
                end
                PH_CLEAR: begin
                    phase       <= PH_SETTLE;
                    settle_left <= SETTLE_LOAD;
                end
                PH_SETTLE: begin
                    if (settle_left == '0) begin
                        phase <= PH_ACQ;
                    end else begin
                        settle_left <= settle_left - SW'(1);
                    end
                end
                PH_READ: begin
                    if (ro_done) begin
                        phase <= PH_ACQ;
                    end
                end
                default: phase <= PH_ACQ;
            endcase
        end
    end
endmodule

// File: rtl/acqt_recorder.sv
module acqt_recorder
    import acqt_pkg::*;
#(
    parameter int BC_W   = 24,
    parameter int FINE_W = 16,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  acq_evt_t          evt,
    input  logic              hit,
    input  logic              stat_rd,
    input  logic [BC_W-1:0]   bc,
    input  logic [FINE_W-1:0] fine,
    output logic [BC_W-1:0]   lat_bc,
    output logic [FINE_W-1:0] lat_fine,
    output logic [CNT_W-1:0]  evt_count,
    output logic [CNT_W-1:0]  ext_in_acq,
    output logic [CNT_W-1:0]  ext_out_acq,
    output logic              full_seen
);
    always_ff @(posedge clk) begin
        if (rst) begin
            lat_bc      <= '0;
            lat_fine    <= '0;
            evt_count   <= '0;
            ext_in_acq  <= '0;
            ext_out_acq <= '0;
            full_seen   <= 1'b0;
        end else begin
            if (evt.take_trig) begin
                lat_bc     <= bc;
                lat_fine   <= hit ? '0 : fine;
                ext_in_acq <= ext_in_acq + CNT_W'(1);
            end
            if (evt.stray_trig) begin
                ext_out_acq <= ext_out_acq + CNT_W'(1);
            end
            if (evt.take_trig || evt.stray_trig) begin
                evt_count <= evt_count + CNT_W'(1);
            end
            if (evt.take_full) begin
                full_seen <= 1'b1;
            end else if (stat_rd) begin
                full_seen <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/acq_timing_ctrl.sv
module acq_timing_ctrl
    import acqt_pkg::*;
#(
    parameter int N_CHIPS    = 4,
    parameter int BC_W       = 24,
    parameter int FINE_W     = 16,
    parameter int CNT_W      = 32,
    parameter int BC_DIV     = 8,
    parameter int SETTLE_CYC = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               card_reset,
    input  logic [N_CHIPS-1:0] thr0,
    input  logic [N_CHIPS-1:0] thr1,
    input  logic [N_CHIPS-1:0] chip_full,
    input  logic               ext_trig,
    input  logic               ro_done,
    input  logic               stat_rd,
    output logic               busy,
    output logic               acq_en,
    output logic               mem_clear,
    output logic [BC_W-1:0]    bc_now,
    output logic [FINE_W-1:0]  fine_now,
    output logic [BC_W-1:0]    lat_bc,
    output logic [FINE_W-1:0]  lat_fine,
    output logic [CNT_W-1:0]   evt_count,
    output logic [CNT_W-1:0]   ext_in_acq,
    output logic [CNT_W-1:0]   ext_out_acq,
    output logic               full_seen
);
    acq_phase_t         phase;
    acq_evt_t           evt;
    logic [N_CHIPS-1:0] chip_hit;
    logic               hit_any;

    // Per-chip hit: either threshold fires.
    for (genvar i = 0; i < N_CHIPS; i++) begin : g_hit
        assign chip_hit[i] = thr0[i] | thr1[i];
    end

    assign hit_any   = acq_en && (|chip_hit);
    assign busy      = phase_is_busy(phase);
    assign acq_en    = !busy;
    assign mem_clear = (phase == PH_CLEAR);

    acqt_sequencer #(
        .N_CHIPS    (N_CHIPS),
        .SETTLE_CYC (SETTLE_CYC)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .chip_full (chip_full),
        .ext_trig  (ext_trig),
        .ro_done   (ro_done),
        .phase     (phase),
        .evt       (evt)
    );

    acqt_bc_stamp #(
        .BC_W   (BC_W),
        .BC_DIV (BC_DIV)
    ) u_bc (
        .clk  (clk),
        .rst  (rst),
        .zero (card_reset || evt.take_full),
        .bc   (bc_now)
    );

    acqt_fine_timer #(
        .FINE_W (FINE_W)
    ) u_fine (
        .clk     (clk),
        .rst     (rst),
        .restart (hit_any),
        .fine    (fine_now)
    );

    acqt_recorder #(
        .BC_W   (BC_W),
        .FINE_W (FINE_W),
        .CNT_W  (CNT_W)
    ) u_rec (
        .clk         (clk),
        .rst         (rst),
        .evt         (evt),
        .hit         (hit_any),
        .stat_rd     (stat_rd),
        .bc          (bc_now),
        .fine        (fine_now),
        .lat_bc      (lat_bc),
        .lat_fine    (lat_fine),
        .evt_count   (evt_count),
        .ext_in_acq  (ext_in_acq),
        .ext_out_acq (ext_out_acq),
        .full_seen   (full_seen)
    );
endmodule

// File: rtl/acq_timing_ctrl_chk.sv
module acq_timing_ctrl_chk #(
    parameter int N_CHIPS = 4,
    parameter int BC_W    = 24,
    parameter int FINE_W  = 16,
    parameter int CNT_W   = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               card_reset,
    input logic [N_CHIPS-1:0] thr0,
    input logic [N_CHIPS-1:0] thr1,
    input logic [N_CHIPS-1:0] chip_full,
    input logic               ext_trig,
    input logic               busy,
    input logic               acq_en,
    input logic               mem_clear,
    input logic [BC_W-1:0]    bc_now,
    input logic [FINE_W-1:0]  fine_now,
    input logic [BC_W-1:0]    lat_bc,
    input logic [CNT_W-1:0]   ext_out_acq,
    input logic               full_seen
);
    a_r9_busy_excl: assert property (@(posedge clk) disable iff (rst)
        busy != acq_en);

    a_r9_clear_busy: assert property (@(posedge clk) disable iff (rst)
        mem_clear |-> busy);

    a_r6_clear_single: assert property (@(posedge clk) disable iff (rst)
        mem_clear |=> !mem_clear);

    a_r6_clear_cause: assert property (@(posedge clk) disable iff (rst)
        (acq_en && !ext_trig && (|chip_full)) |=> mem_clear);

    a_r7_trig_wins: assert property (@(posedge clk) disable iff (rst)
        (acq_en && ext_trig) |=> (busy && !mem_clear));

    a_r2_bc_zero: assert property (@(posedge clk) disable iff (rst)
        card_reset |=> (bc_now == '0));

    a_r1_bc_step: assert property (@(posedge clk) disable iff (rst)
        (bc_now == '0) || (BC_W'(bc_now - $past(bc_now)) <= BC_W'(1)));

    a_r3_fine_restart: assert property (@(posedge clk) disable iff (rst)
        (acq_en && (|(thr0 | thr1))) |=> (fine_now == '0));

    a_r4_latch_hold: assert property (@(posedge clk) disable iff (rst)
        !(acq_en && ext_trig) |=> $stable(lat_bc));

    a_r5_out_count: assert property (@(posedge clk) disable iff (rst)
        (ext_trig && !acq_en) |=> (ext_out_acq == CNT_W'($past(ext_out_acq) + CNT_W'(1))));

    a_r8_flag_on_clear: assert property (@(posedge clk) disable iff (rst)
        mem_clear |-> full_seen);
endmodule

bind acq_timing_ctrl acq_timing_ctrl_chk #(
    .N_CHIPS (N_CHIPS),
    .BC_W    (BC_W),
    .FINE_W  (FINE_W),
    .CNT_W   (CNT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .card_reset  (card_reset),
    .thr0        (thr0),
    .thr1        (thr1),
    .chip_full   (chip_full),
    .ext_trig    (ext_trig),
    .busy        (busy),
    .acq_en      (acq_en),
    .mem_clear   (mem_clear),
    .bc_now      (bc_now),
    .fine_now    (fine_now),
    .lat_bc      (lat_bc),
    .ext_out_acq (ext_out_acq),
    .full_seen   (full_seen)
);

// File: tb/acq_timing_ctrl_tb.sv
module acq_timing_ctrl_tb;
    localparam int NC  = 4;
    localparam int BW  = 8;
    localparam int FW  = 5;
    localparam int CW  = 4;
    localparam int DIV = 8;
    localparam int SET = 4;
    localparam int FMAX = (1 << FW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          card_reset = 1'b0;
    logic [NC-1:0] thr0 = '0, thr1 = '0, chip_full = '0;
    logic          ext_trig = 1'b0, ro_done = 1'b0, stat_rd = 1'b0;
    logic          busy, acq_en, mem_clear, full_seen;
    logic [BW-1:0] bc_now, lat_bc;
    logic [FW-1:0] fine_now, lat_fine;
    logic [CW-1:0] evt_count, ext_in_acq, ext_out_acq;

    always #4 clk = ~clk;

    acq_timing_ctrl #(
        .N_CHIPS(NC), .BC_W(BW), .FINE_W(FW), .CNT_W(CW),
        .BC_DIV(DIV), .SETTLE_CYC(SET)
    ) u_dut (
        .clk(clk), .rst(rst), .card_reset(card_reset),
        .thr0(thr0), .thr1(thr1), .chip_full(chip_full),
        .ext_trig(ext_trig), .ro_done(ro_done), .stat_rd(stat_rd),
        .busy(busy), .acq_en(acq_en), .mem_clear(mem_clear),
        .bc_now(bc_now), .fine_now(fine_now),
        .lat_bc(lat_bc), .lat_fine(lat_fine),
        .evt_count(evt_count), .ext_in_acq(ext_in_acq),
        .ext_out_acq(ext_out_acq), .full_seen(full_seen)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // Expected-state model derived from the requirements.
    int  n_since_bc, m_since_hit, ph, settle_r;
    int  e_evt, e_in, e_out, e_lb, e_lf;
    bit  e_flag;

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_all();
        int fexp;
        fexp = (m_since_hit > FMAX) ? FMAX : m_since_hit;
        chk("R1 bc_now", int'(bc_now), (n_since_bc / DIV) % (1 << BW));
        chk("R3 fine_now", int'(fine_now), fexp);
        chk("R4 acq_en", int'(acq_en), (ph == 0) ? 1 : 0);
        chk("R9 busy", int'(busy), (ph != 0) ? 1 : 0);
        chk("R6 mem_clear", int'(mem_clear), (ph == 1) ? 1 : 0);
        chk("R4 lat_bc", int'(lat_bc), e_lb);
        chk("R4 lat_fine", int'(lat_fine), e_lf);
        chk("R5 evt_count", int'(evt_count), e_evt % (1 << CW));
        chk("R5 ext_in_acq", int'(ext_in_acq), e_in % (1 << CW));
        chk("R5 ext_out_acq", int'(ext_out_acq), e_out % (1 << CW));
        chk("R8 full_seen", int'(full_seen), int'(e_flag));
    endtask

    // One clock cycle with the given inputs, model update, then full check.
    task automatic cyc(input logic [NC-1:0] t0, input logic [NC-1:0] t1,
                       input logic [NC-1:0] fl, input bit ext, input bit done,
                       input bit crst, input bit rd);
        bit acc, hit, acc_ext, acc_full;
        thr0 = t0; thr1 = t1; chip_full = fl; ext_trig = ext;
        ro_done = done; card_reset = crst; stat_rd = rd;
        @(posedge clk);
        acc      = (ph == 0);
        hit      = acc && (|(t0 | t1));
        acc_ext  = acc && ext;
        acc_full = acc && !ext && (|fl);
        if (acc_ext) begin
            e_lb = (n_since_bc / DIV) % (1 << BW);
            e_lf = hit ? 0 : ((m_since_hit > FMAX) ? FMAX : m_since_hit);
            e_in++;
        end
        if (ext) begin
            e_evt++;
            if (!acc) e_out++;
        end
        if (acc_full) e_flag = 1;
        else if (rd) e_flag = 0;
        n_since_bc  = (crst || acc_full) ? 0 : n_since_bc + 1;
        m_since_hit = hit ? 0 : ((m_since_hit < FMAX) ? m_since_hit + 1 : FMAX);
        case (ph)
            0: if (acc_ext) ph = 3; else if (acc_full) ph = 1;
            1: begin ph = 2; settle_r = SET; end
            2: if (settle_r == 1) ph = 0; else settle_r--;
            default: if (done) ph = 0;
        endcase
        @(negedge clk);
        thr0 = '0; thr1 = '0; chip_full = '0; ext_trig = 0;
        ro_done = 0; card_reset = 0; stat_rd = 0;
        check_all();
    endtask

    task automatic idle(int k);
        for (int i = 0; i < k; i++) cyc('0, '0, '0, 0, 0, 0, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin : stim
        n_since_bc = 0; m_since_hit = 0; ph = 0; settle_r = 0;
        e_evt = 0; e_in = 0; e_out = 0; e_lb = 0; e_lf = 0; e_flag = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R10: reset state
        chk("R10 acq_en", int'(acq_en), 1);
        chk("R10 bc_now", int'(bc_now), 0);
        chk("R10 fine_now", int'(fine_now), 0);
        chk("R10 evt_count", int'(evt_count), 0);
        chk("R10 full_seen", int'(full_seen), 0);

        // R1/R3: free run to saturation and several bc steps
        idle(40);

        // R3: hit sweep over every chip and threshold combination
        for (int c = 0; c < NC; c++) begin
            for (int k = 1; k < 4; k++) begin
                logic [NC-1:0] v;
                v = NC'(1) << c;
                cyc((k & 1) ? v : '0, (k & 2) ? v : '0, '0, 0, 0, 0, 0);
                idle(c * 3 + k);
            end
        end

        // R4: triggers at several delays after a hit; stray activity while busy
        for (int d = 0; d < 6; d++) begin
            cyc('0, 4'b0010, '0, 0, 0, 0, 0);
            idle(d * 7);
            cyc('0, '0, '0, 1, 0, 0, 0);
            cyc(4'b1111, 4'b1111, 4'b1111, 1, 0, 0, 0); // ignored hits/full, stray trig (R5)
            idle(d);
            cyc('0, '0, '0, 0, 1, 0, 0);
        end

        // R4: trigger coincident with a hit latches fine 0
        idle(9);
        cyc(4'b1000, '0, '0, 1, 0, 0, 0);
        cyc('0, '0, '0, 0, 1, 0, 0);

        // R6/R8: memory-full from each chip, status reads
        for (int c = 0; c < NC; c++) begin
            idle(5 + c);
            cyc('0, '0, NC'(1) << c, 0, 0, 0, 0);
            cyc('0, '0, '0, 0, 0, 0, 0);
            cyc('0, '0, '0, 1, 0, 0, 0);          // stray trigger during settle
            idle(SET + 2);
            cyc('0, '0, '0, 0, 0, 0, 1);          // read clears flag
        end
        // R8: read on the same edge as accepted full keeps flag set
        cyc('0, '0, 4'b0100, 0, 0, 0, 1);
        idle(SET + 3);

        // R7: trigger and full together: readout, no clear
        cyc('0, '0, 4'b0001, 1, 0, 0, 0);
        idle(3);
        cyc('0, '0, '0, 0, 1, 0, 0);

        // R2: card reset while acquiring and while busy, counters kept
        idle(20);
        cyc('0, '0, '0, 0, 0, 1, 0);
        idle(11);
        cyc('0, '0, '0, 1, 0, 0, 0);
        cyc('0, '0, '0, 0, 0, 1, 0);
        cyc('0, '0, '0, 0, 1, 0, 0);

        // R5: counter wrap
        for (int i = 0; i < 20; i++) begin
            cyc('0, '0, '0, 1, 0, 0, 0);
            cyc('0, '0, '0, 1, 1, 0, 0);
        end

        // R1: timestamp wrap
        idle(DIV * (1 << BW) + 20);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule